// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, for each destination MAC address presented to it, whether the frame carrying it should be accepted. A multicast (group) address is accepted when its bin in a 256-bin hash table is set. The bin number is taken from an Ethernet CRC-32 of the six address bytes. A unicast address is accepted only when it equals the stored station address. A promiscuous control bit accepts everything.

The address arrives as one 48-bit word with a valid strobe. The first transmitted byte is in bits [47:40], so its group bit is bit 40. The decision and the bin index appear one clock later. Software reaches the table, the station address and the control bit through a simple word register port. Single bins can also be set or cleared by bin number, or by giving a MAC address whose hash selects the bin.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all table words, both station words and the control word read zero. A group address presented after reset is rejected.
- R2: The bin index is computed as follows. Start a CRC-32 register at 0xFFFFFFFF with polynomial 0x04C11DB7. Feed the bytes from bits [47:40] down to [7:0], each byte least significant bit first. Do not apply a final inversion. Bit-reverse the result and keep its top 8 bits. `hash_idx` shows this index in the cycle after `addr_valid`.
- R3: Bin e is held in table word e/32 (register addresses 0 to 7) at bit position 31-(e mod 32). Bin 0 is bit 31 of word 0, and bin 255 is bit 0 of word 7.
- R4: A bin command with `cmd_set`=1 sets the addressed bin, and one with `cmd_set`=0 clears it. Every other table bit is left as it was.
- R5: With `cmd_by_mac`=1, the command acts on the bin selected by the R2 hash of `cmd_mac`, and `cmd_idx` is ignored.
- R6: A register write to address 0 to 7 replaces the whole word. A bin command in the same cycle is applied on top of the written value.
- R7: A group address (bit 40 set) passes when its bin is 1. An individual address (bit 40 clear) that differs from the station address is rejected, even if its bin is 1.
- R8: The station address is held byte-reversed. Register 8 holds bytes 5,4,3,2 (byte 0 being bits [47:40]) from bit 31 down. Register 9 bits [31:16] hold bytes 1,0, and its bits [15:0] always read zero. An exact match passes.
- R9: Bit 0 of register 10 enables promiscuous mode, and in that mode every address passes.
- R10: `pass_valid` is high exactly in the cycle after a cycle with `addr_valid` high. `pass` is low whenever `pass_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | Destination address strobe |
| addr_mac | input | 48 | Destination address, first byte in [47:40] |
| pass_valid | output | 1 | Decision valid |
| pass | output | 1 | Address accepted |
| hash_idx | output | 8 | Bin index of the last address |
| reg_addr | input | 4 | Register address (0-7 table, 8-9 station, 10 control) |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| cmd_valid | input | 1 | Bin command strobe |
| cmd_set | input | 1 | 1 sets, 0 clears the bin |
| cmd_by_mac | input | 1 | Take the bin from the hash of cmd_mac |
| cmd_idx | input | 8 | Bin number for direct commands |
| cmd_mac | input | 48 | Address whose bin is set or cleared |

## Verification
The decision path is probed in several ways, and each probe isolates one cause of acceptance:
- Group addresses whose bins were set are probed, which confirms both the CRC index and the packing of bins into the table.
- Unicast addresses whose bins were set are probed, to show that the table alone never admits an individual address.
- Exact and one-bit-off copies of the station address are probed, to test the byte-reversed compare.
- Probes are repeated with the promiscuous bit on.

Directed bin commands at bins 0, 37 and 255 pin down the MSB-first layout. A register write and a bin command in the same cycle settle their ordering. A random mix of commands, writes and probes is then checked against a reflected-CRC model in the bench.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   localparam int WORD_W     = 32;
   localparam int MAC_BYTES  = 6;
   localparam int MAC_W      = 8 * MAC_BYTES;
   localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;
   localparam logic [31:0] CRC_PRESET = 32'hFFFFFFFF;

   // one byte into a non-reflected CRC register, data LSB first
   function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                 input logic [7:0]  d);
      logic [31:0] r;
      logic        fb;
      r = c_in;
      for (int i = 0; i < 8; i++) begin
         fb = r[31] ^ d[i];
         r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
      end
      return r;
   endfunction
endpackage

// File: rtl/mhf_crc_idx.sv
module mhf_crc_idx
   import mhf_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic [MAC_W-1:0] mac,
   output logic [IDX_W-1:0] idx
);
   if (IDX_W < 1 || IDX_W > 32) begin : g_bad_w
      $error("mhf_crc_idx: IDX_W must be 1..32");
   end

   logic [31:0] stage [MAC_BYTES+1];
   assign stage[0] = CRC_PRESET;

   for (genvar g = 0; g < MAC_BYTES; g++) begin : g_byte
      assign stage[g+1] = crc_step_byte(stage[g], mac[MAC_W-1-8*g -: 8]);
   end

   // top bits of the non-reflected register equal the reversed reflected CRC
   assign idx = stage[MAC_BYTES][31 -: IDX_W];
endmodule

// File: rtl/mhf_table.sv
module mhf_table
   import mhf_pkg::*;
#(
   parameter int NUM_REGS = 8,
   localparam int SEL_W = $clog2(NUM_REGS),
   localparam int BIT_W = $clog2(WORD_W),
   localparam int IDX_W = SEL_W + BIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              cmd_en,
   input  logic              cmd_set,
   input  logic [IDX_W-1:0]  cmd_idx,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [WORD_W-1:0] rd_word,
   input  logic [IDX_W-1:0]  look_idx,
   output logic              look_bit
);
   if (NUM_REGS < 2 || (1 << SEL_W) != NUM_REGS) begin : g_bad_n
      $error("mhf_table: NUM_REGS must be a power of two, at least 2");
   end

   logic [WORD_W-1:0] tbl_q [NUM_REGS];
   logic [WORD_W-1:0] tbl_d [NUM_REGS];

   logic [SEL_W-1:0] cmd_sel;
   logic [BIT_W-1:0] cmd_bit;
   logic [SEL_W-1:0] look_sel;
   logic [BIT_W-1:0] look_bit_pos;

   // MSB-first packing: bin 0 is the top bit of word 0
   assign cmd_sel      = cmd_idx[IDX_W-1:BIT_W];
   assign cmd_bit      = BIT_W'(WORD_W-1) - cmd_idx[BIT_W-1:0];
   assign look_sel     = look_idx[IDX_W-1:BIT_W];
   assign look_bit_pos = BIT_W'(WORD_W-1) - look_idx[BIT_W-1:0];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
      always_comb begin
         tbl_d[g] = tbl_q[g];
         if (wr_en && wr_sel == SEL_W'(g))
            tbl_d[g] = wr_data;
         if (cmd_en && cmd_sel == SEL_W'(g))
            tbl_d[g][cmd_bit] = cmd_set;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) tbl_q[g] <= '0;
         else        tbl_q[g] <= tbl_d[g];
      end
   end

   assign rd_word  = tbl_q[rd_sel];
   assign look_bit = tbl_q[look_sel][look_bit_pos];

   // R4
   set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_en && cmd_set |=> tbl_q[$past(cmd_sel)][$past(cmd_bit)]);
   // R4
   clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_en && !cmd_set |=> !tbl_q[$past(cmd_sel)][$past(cmd_bit)]);
   // R6
   wr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !cmd_en |=> tbl_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
   import mhf_pkg::*;
#(
   parameter int IDX_W      = 8,
   parameter bit STATION_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [MAC_W-1:0] in_mac,
   input  logic [IDX_W-1:0] in_idx,
   input  logic             bin_hit,
   input  logic [MAC_W-1:0] sta_mac,
   input  logic             promisc,
   output logic             out_valid,
   output logic             out_pass,
   output logic [IDX_W-1:0] out_idx
);
   logic sta_hit;
   logic grp_hit;
   logic accept;

   if (STATION_EN) begin : g_sta
      assign sta_hit = (in_mac == sta_mac);
   end else begin : g_nosta
      assign sta_hit = 1'b0;
   end

   // group bit is the LSB of the first transmitted byte
   assign grp_hit = in_mac[MAC_W-8] & bin_hit;
   assign accept  = promisc | sta_hit | grp_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pass  <= 1'b0;
         out_idx   <= '0;
      end else begin
         out_valid <= in_valid;
         out_pass  <= in_valid & accept;
         if (in_valid) out_idx <= in_idx;
      end
   end

   // R9
   promisc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && promisc |=> out_pass);
   // R7
   unicast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !promisc && !in_mac[MAC_W-8] && (in_mac != sta_mac) |=> !out_pass);
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
   import mhf_pkg::*;
#(
   parameter int NUM_REGS   = 8,
   parameter bit STATION_EN = 1'b1,
   localparam int SEL_W = $clog2(NUM_REGS),
   localparam int IDX_W = SEL_W + $clog2(WORD_W),
   localparam int RA_W  = $clog2(NUM_REGS + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_valid,
   input  logic [MAC_W-1:0]  addr_mac,
   output logic              pass_valid,
   output logic              pass,
   output logic [IDX_W-1:0]  hash_idx,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic              reg_we,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic              cmd_valid,
   input  logic              cmd_set,
   input  logic              cmd_by_mac,
   input  logic [IDX_W-1:0]  cmd_idx,
   input  logic [MAC_W-1:0]  cmd_mac
);
   localparam logic [RA_W-1:0] A_STA_LO = RA_W'(NUM_REGS);
   localparam logic [RA_W-1:0] A_STA_HI = RA_W'(NUM_REGS + 1);
   localparam logic [RA_W-1:0] A_CTRL   = RA_W'(NUM_REGS + 2);

   if (IDX_W > 32) begin : g_bad_idx
      $error("mcast_hash_filter: table larger than CRC width");
   end

   logic [WORD_W-1:0] sta_lo_q;
   logic [15:0]       sta_hi_q;
   logic              promisc_q;
   logic [MAC_W-1:0]  sta_mac;
   logic [IDX_W-1:0]  probe_idx;
   logic [IDX_W-1:0]  cmd_hash_idx;
   logic [IDX_W-1:0]  cmd_bin;
   logic              tbl_wr;
   logic              in_tbl;
   logic [WORD_W-1:0] tbl_rd;
   logic              bin_hit;

   mhf_crc_idx #(.IDX_W(IDX_W)) u_crc_probe (.mac(addr_mac), .idx(probe_idx));
   mhf_crc_idx #(.IDX_W(IDX_W)) u_crc_cmd   (.mac(cmd_mac),  .idx(cmd_hash_idx));

   assign cmd_bin = cmd_by_mac ? cmd_hash_idx : cmd_idx;
   assign in_tbl  = (reg_addr < RA_W'(NUM_REGS));
   assign tbl_wr  = reg_we & in_tbl;

   mhf_table #(.NUM_REGS(NUM_REGS)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_wr),
      .wr_sel   (reg_addr[SEL_W-1:0]),
      .wr_data  (reg_wdata),
      .cmd_en   (cmd_valid),
      .cmd_set  (cmd_set),
      .cmd_idx  (cmd_bin),
      .rd_sel   (reg_addr[SEL_W-1:0]),
      .rd_word  (tbl_rd),
      .look_idx (probe_idx),
      .look_bit (bin_hit)
   );

   // station words hold the address byte-reversed
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sta_lo_q  <= '0;
         sta_hi_q  <= '0;
         promisc_q <= 1'b0;
      end else if (reg_we) begin
         if (reg_addr == A_STA_LO) sta_lo_q  <= reg_wdata;
         if (reg_addr == A_STA_HI) sta_hi_q  <= reg_wdata[31:16];
         if (reg_addr == A_CTRL)   promisc_q <= reg_wdata[0];
      end
   end

   assign sta_mac = {sta_hi_q[7:0], sta_hi_q[15:8],
                     sta_lo_q[7:0], sta_lo_q[15:8], sta_lo_q[23:16], sta_lo_q[31:24]};

   always_comb begin
      if (in_tbl)                     reg_rdata = tbl_rd;
      else if (reg_addr == A_STA_LO)  reg_rdata = sta_lo_q;
      else if (reg_addr == A_STA_HI)  reg_rdata = {sta_hi_q, 16'h0000};
      else if (reg_addr == A_CTRL)    reg_rdata = {{(WORD_W-1){1'b0}}, promisc_q};
      else                            reg_rdata = '0;
   end

   mhf_decide #(.IDX_W(IDX_W), .STATION_EN(STATION_EN)) u_decide (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (addr_valid),
      .in_mac    (addr_mac),
      .in_idx    (probe_idx),
      .bin_hit   (bin_hit),
      .sta_mac   (sta_mac),
      .promisc   (promisc_q),
      .out_valid (pass_valid),
      .out_pass  (pass),
      .out_idx   (hash_idx)
   );

   // R10
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass_valid == $past(addr_valid));
   // R10
   pass_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_valid |-> !pass);
   // R8
   sta_hi_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == A_STA_HI |-> reg_rdata[15:0] == 16'h0000);
endmodule

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb;
   localparam int NREG = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_valid = 1'b0;
   logic [47:0] addr_mac = '0;
   logic        pass_valid, pass;
   logic [7:0]  hash_idx;
   logic [3:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cmd_valid = 1'b0, cmd_set = 1'b0, cmd_by_mac = 1'b0;
   logic [7:0]  cmd_idx = '0;
   logic [47:0] cmd_mac = '0;

   always #5 clk = ~clk;

   mcast_hash_filter u_dut (
      .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_mac(addr_mac),
      .pass_valid(pass_valid), .pass(pass), .hash_idx(hash_idx),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cmd_valid(cmd_valid), .cmd_set(cmd_set), .cmd_by_mac(cmd_by_mac),
      .cmd_idx(cmd_idx), .cmd_mac(cmd_mac)
   );

   logic [31:0] m_tbl [NREG];
   logic [31:0] m_lo, m_hi;
   logic        m_prom;
   int          n_tests = 0, n_fail = 0;
   bit          done = 1'b0;
   logic [47:0] pool [8];

   // reflected CRC model; index is its low byte read in reverse
   function automatic logic [7:0] exp_idx(input logic [47:0] mac);
      logic [31:0] c;
      logic [7:0]  b, r;
      c = 32'hFFFFFFFF;
      for (int k = 0; k < 6; k++) begin
         b = mac[47-8*k -: 8];
         for (int j = 0; j < 8; j++)
            c = (c[0] ^ b[j]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      for (int k = 0; k < 8; k++) r[7-k] = c[k];
      return r;
   endfunction

   function automatic logic [47:0] m_sta();
      return {m_hi[23:16], m_hi[31:24], m_lo[7:0], m_lo[15:8], m_lo[23:16], m_lo[31:24]};
   endfunction

   function automatic logic m_bin(input logic [7:0] i);
      return m_tbl[i[7:5]][5'd31 - i[4:0]];
   endfunction

   function automatic logic exp_pass(input logic [47:0] mac);
      return m_prom | (mac == m_sta()) | (mac[40] & m_bin(exp_idx(mac)));
   endfunction

   function automatic logic [31:0] m_read(input logic [3:0] a);
      if (a < 4'd8)  return m_tbl[a[2:0]];
      if (a == 4'd8) return m_lo;
      if (a == 4'd9) return m_hi;
      if (a == 4'd10) return {31'b0, m_prom};
      return 32'h0;
   endfunction

   task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic m_apply_write(input logic [3:0] a, input logic [31:0] d);
      if (a < 4'd8)       m_tbl[a[2:0]] = d;
      else if (a == 4'd8) m_lo = d;
      else if (a == 4'd9) m_hi = {d[31:16], 16'h0};
      else if (a == 4'd10) m_prom = d[0];
   endtask

   task automatic m_apply_cmd(input logic s, input logic bym, input logic [7:0] i, input logic [47:0] mac);
      logic [7:0] e;
      e = bym ? exp_idx(mac) : i;
      m_tbl[e[7:5]][5'd31 - e[4:0]] = s;
   endtask

   task automatic do_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      m_apply_write(a, d);
   endtask

   task automatic do_cmd(input logic s, input logic bym, input logic [7:0] i, input logic [47:0] mac);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_set = s; cmd_by_mac = bym; cmd_idx = i; cmd_mac = mac;
      @(negedge clk);
      cmd_valid = 1'b0;
      m_apply_cmd(s, bym, i, mac);
   endtask

   task automatic do_both(input logic [3:0] a, input logic [31:0] d, input logic s, input logic [7:0] i);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      cmd_valid = 1'b1; cmd_set = s; cmd_by_mac = 1'b0; cmd_idx = i;
      @(negedge clk);
      reg_we = 1'b0; cmd_valid = 1'b0;
      m_apply_write(a, d);
      m_apply_cmd(s, 1'b0, i, '0);
   endtask

   task automatic rd_chk(input logic [3:0] a, input string rq);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(reg_rdata === m_read(a), rq, 64'(reg_rdata), 64'(m_read(a)));
   endtask

   task automatic probe(input logic [47:0] mac, input string rq);
      logic e;
      logic [7:0] ei;
      e = exp_pass(mac);
      ei = exp_idx(mac);
      @(negedge clk);
      addr_valid = 1'b1; addr_mac = mac;
      @(negedge clk);
      addr_valid = 1'b0;
      chk(pass_valid === 1'b1, "R10 valid", 64'(pass_valid), 64'd1);
      chk(hash_idx === ei, "R2 index", 64'(hash_idx), 64'(ei));
      chk(pass === e, rq, 64'(pass), 64'(e));
      @(negedge clk);
      chk(pass_valid === 1'b0 && pass === 1'b0, "R10 idle", 64'({pass_valid, pass}), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [47:0] mac;
      int          op;
      void'($urandom(32'd20240611));
      for (int k = 0; k < NREG; k++) m_tbl[k] = '0;
      m_lo = '0; m_hi = '0; m_prom = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 11; a++) rd_chk(4'(a), "R1 reset read");
      probe(48'h01005E000001, "R1 group rejected after reset");

      // R3 bin layout
      do_cmd(1'b1, 1'b0, 8'd0, '0);
      @(negedge clk); reg_addr = 4'd0; #1;
      chk(reg_rdata === 32'h80000000, "R3 bin 0", 64'(reg_rdata), 64'h80000000);
      do_cmd(1'b1, 1'b0, 8'd255, '0);
      @(negedge clk); reg_addr = 4'd7; #1;
      chk(reg_rdata === 32'h00000001, "R3 bin 255", 64'(reg_rdata), 64'h1);
      do_cmd(1'b1, 1'b0, 8'd37, '0);
      @(negedge clk); reg_addr = 4'd1; #1;
      chk(reg_rdata === 32'h04000000, "R3 bin 37", 64'(reg_rdata), 64'h04000000);

      // R4 clear leaves neighbours
      do_write(4'd3, 32'hFFFFFFFF);
      do_cmd(1'b0, 1'b0, 8'd100, '0);
      @(negedge clk); reg_addr = 4'd3; #1;
      chk(reg_rdata === 32'hF7FFFFFF, "R4 clear one bit", 64'(reg_rdata), 64'hF7FFFFFF);
      do_cmd(1'b1, 1'b0, 8'd100, '0);
      rd_chk(4'd3, "R4 set one bit");

      // R6 same-cycle write and command
      do_both(4'd2, 32'h0000FFFF, 1'b1, 8'd64);
      @(negedge clk); reg_addr = 4'd2; #1;
      chk(reg_rdata === 32'h8000FFFF, "R6 write then set", 64'(reg_rdata), 64'h8000FFFF);
      do_both(4'd2, 32'hFFFFFFFF, 1'b0, 8'd65);
      @(negedge clk); reg_addr = 4'd2; #1;
      chk(reg_rdata === 32'hBFFFFFFF, "R6 write then clear", 64'(reg_rdata), 64'hBFFFFFFF);

      // clear the table for the address tests
      for (int k = 0; k < NREG; k++) do_write(4'(k), 32'h0);

      // R5 command by address, cmd_idx ignored
      mac = 48'h01005E0000FB;
      probe(mac, "R7 group with clear bin");
      do_cmd(1'b1, 1'b1, ~exp_idx(mac), mac);
      rd_chk({1'b0, exp_idx(mac) >> 5}, "R5 set by address");
      rd_chk({1'b0, (~exp_idx(mac)) >> 5}, "R5 cmd_idx ignored");
      probe(mac, "R7 group with set bin");
      do_cmd(1'b0, 1'b1, 8'd0, mac);
      probe(mac, "R5 cleared by address");

      // R7 individual address with its bin set
      mac = 48'h02AABBCCDDEE;
      do_cmd(1'b1, 1'b1, 8'd0, mac);
      probe(mac, "R7 unicast not admitted by table");

      // R8 station address
      do_write(4'd8, 32'h55443322);
      do_write(4'd9, 32'h1100FFFF);
      rd_chk(4'd9, "R8 upper word low half zero");
      chk(m_hi === 32'h11000000, "R8 model", 64'(m_hi), 64'h11000000);
      probe(48'h001122334455, "R8 exact station match");
      probe(48'h001122334454, "R8 near miss rejected");
      probe(48'h011122334455, "R8 group near miss");

      // R9 promiscuous
      do_write(4'd10, 32'h1);
      rd_chk(4'd10, "R9 control read");
      probe(48'h02DEADBEEF01, "R9 promiscuous unicast");
      probe(48'h03DEADBEEF01, "R9 promiscuous group");
      do_write(4'd10, 32'h0);
      probe(48'h02DEADBEEF01, "R9 promiscuous off");

      // random mix
      for (int k = 0; k < 8; k++) pool[k] = {$urandom, $urandom} & 48'hFFFFFFFFFFFF;
      for (int it = 0; it < 400; it++) begin
         op = $urandom_range(0, 5);
         mac = pool[$urandom_range(0, 7)];
         if ($urandom_range(0, 1) == 1) mac[40] = 1'b1;
         case (op)
            0: do_cmd(1'b1, 1'b1, 8'($urandom), mac);
            1: do_cmd(1'b0, 1'b1, 8'($urandom), mac);
            2: do_cmd(1'($urandom), 1'b0, 8'($urandom), '0);
            3: do_write(4'($urandom_range(0, 7)), $urandom);
            4: rd_chk(4'($urandom_range(0, 15)), "R3 random read");
            default: probe(mac, "R7 random probe");
         endcase
         if (it == 200) begin
            do_write(4'd8, {mac[7:0], mac[15:8], mac[23:16], mac[31:24]});
            do_write(4'd9, {mac[39:32], mac[47:40], 16'h0});
            probe(mac, "R8 random station");
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule